// File: doc/BRIEF.md
# Dual-Pipe SIMD Arithmetic Issue Sequencer

This block sits between a thread scheduler and two arithmetic pipes that do not do the same work. Pipe 0 runs simple integer and float operations such as add and multiply. Pipe 1 runs transcendental operations such as square root, sine and cosine. Each instruction arrives tagged with an operation class and a SIMD width. The block routes it to the pipe that can run that class. It then breaks the instruction into 8-lane phases and issues one phase per clock:

- SIMD8 takes one phase.
- SIMD16 takes two phases.
- SIMD32 takes four phases.

Each phase produces an execute strobe that carries a lane-group index. A placeholder lane operation stands in for the arithmetic.

The scheduler offers up to two instructions per cycle, on slot 0 and slot 1. Each slot is a valid/ready stream. A transfer happens on a rising clock edge where both valid and ready are high. Once the scheduler raises valid, it must hold valid and the payload steady until the transfer takes place. Ready never depends on the slot's own valid, but slot 1's ready does depend on what slot 0 offers. When both slots want the same pipe, slot 0 wins. A pipe that still has phases left to issue holds off new work: its ready is low and it asserts busy. An instruction with an illegal code is taken immediately, is never issued, and raises an error flag for that slot on the next cycle.

Top module: `simd_issue_seq`

## Requirements
- R1: Class codes 0 to 3 (simple integer/float) issue only on pipe 0. Codes 4 to 6 (transcendental) issue only on pipe 1.
- R2: A SIMD8 instruction (width code 0) accepted at edge N fires exactly once, in the cycle after edge N. That phase has group 0 and last high.
- R3: A SIMD16 instruction (width code 1) fires in two consecutive cycles with groups 0 then 1. Last is high only on the second phase.
- R4: A SIMD32 instruction (width code 2) fires in four consecutive cycles with groups 0, 1, 2, 3. Last is high only on group 3.
- R5: While a pipe has phases remaining after the current one, busy is high and that pipe takes no new instruction. In a pipe's idle cycle or on its final phase, the pipe can take the next instruction, so phases follow back to back.
- R6: Two valid, legal instructions on the two slots that target different free pipes are both accepted in the same cycle.
- R7: When both slots hold legal instructions for the same pipe, slot 1's ready is low for as long as slot 0's instruction is present.
- R8: Class code 7 or width code 3 is illegal. That slot's ready is high, nothing is issued, and the slot's err output is high in the next cycle only.
- R9: The phase result is data + 8*group on pipe 0 and (~data) + group on pipe 1, computed modulo 2^DATA_W.
- R10: During reset, no fire, busy or err output is high and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 instruction present |
| s0_ready | output | 1 | Slot 0 can be taken this cycle |
| s0_cls | input | 3 | Slot 0 operation class |
| s0_simd | input | 2 | Slot 0 width code: 0=SIMD8, 1=SIMD16, 2=SIMD32 |
| s0_data | input | DATA_W | Slot 0 operand |
| s0_err | output | 1 | Slot 0 illegal instruction dropped |
| s1_valid | input | 1 | Slot 1 instruction present |
| s1_ready | output | 1 | Slot 1 can be taken this cycle |
| s1_cls | input | 3 | Slot 1 operation class |
| s1_simd | input | 2 | Slot 1 width code |
| s1_data | input | DATA_W | Slot 1 operand |
| s1_err | output | 1 | Slot 1 illegal instruction dropped |
| p0_fire | output | 1 | Pipe 0 phase strobe |
| p0_group | output | 2 | Pipe 0 lane group |
| p0_last | output | 1 | Pipe 0 final phase |
| p0_result | output | DATA_W | Pipe 0 lane result |
| p0_busy | output | 1 | Pipe 0 has phases left after this one |
| p1_fire | output | 1 | Pipe 1 phase strobe |
| p1_group | output | 2 | Pipe 1 lane group |
| p1_last | output | 1 | Pipe 1 final phase |
| p1_result | output | DATA_W | Pipe 1 lane result |
| p1_busy | output | 1 | Pipe 1 has phases left after this one |

## Verification
The bench goes after the points where a pipe hands over from one instruction to the next. If the last phase did not reopen the pipe, a bubble would appear between phases. If the pipe reopened one phase too early, a SIMD32 would be cut short or its groups would be overwritten. It also drives both slots at the same pipe at once. A design that got the priority wrong would double-load that pipe or drop slot 1 while showing it as accepted. Illegal codes are mixed in with legal traffic. A design that routed them anyway would show stray fire strobes, and one that stalled on them would hold ready low.

// File: rtl/simd_issue_pkg.sv
package simd_issue_pkg;
  localparam int CLS_W = 3;
  localparam int WID_W = 2;
  localparam int GRP_W = 2;

  typedef enum logic [WID_W-1:0] {
    WIDTH_8  = 2'd0,
    WIDTH_16 = 2'd1,
    WIDTH_32 = 2'd2,
    WIDTH_NA = 2'd3
  } simd_width_e;

  function automatic logic is_illegal(logic [CLS_W-1:0] cls, logic [WID_W-1:0] wid);
    return (cls == 3'd7) || (wid == WIDTH_NA);
  endfunction

  // 0 = simple pipe, 1 = transcendental pipe
  function automatic logic pipe_of(logic [CLS_W-1:0] cls);
    return cls[2];
  endfunction

  function automatic logic [GRP_W-1:0] final_group(logic [WID_W-1:0] wid);
    case (wid)
      WIDTH_8:  return 2'd0;
      WIDTH_16: return 2'd1;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/issue_router.sv
module issue_router
  import simd_issue_pkg::*;
(
  input  logic             a_valid,
  input  logic [CLS_W-1:0] a_cls,
  input  logic [WID_W-1:0] a_wid,
  input  logic             b_valid,
  input  logic [CLS_W-1:0] b_cls,
  input  logic [WID_W-1:0] b_wid,
  input  logic [1:0]       pipe_free,
  output logic             a_ready,
  output logic             b_ready,
  output logic             a_grant,
  output logic             b_grant,
  output logic             a_bad,
  output logic             b_bad,
  output logic             a_tgt,
  output logic             b_tgt,
  output logic [1:0]       load,
  output logic [1:0]       from_b
);
  logic a_claims_b_pipe;

  always_comb begin
    a_bad = is_illegal(a_cls, a_wid);
    b_bad = is_illegal(b_cls, b_wid);
    a_tgt = pipe_of(a_cls);
    b_tgt = pipe_of(b_cls);
    a_claims_b_pipe = a_valid && !a_bad && (a_tgt == b_tgt);
    a_ready = a_bad || pipe_free[a_tgt];
    b_ready = b_bad || (pipe_free[b_tgt] && !a_claims_b_pipe);
    a_grant = a_valid && !a_bad && pipe_free[a_tgt];
    b_grant = b_valid && !b_bad && b_ready;
    for (int p = 0; p < 2; p++) begin
      from_b[p] = !(a_grant && (a_tgt == p[0]));
      load[p]   = (a_grant && (a_tgt == p[0])) || (b_grant && (b_tgt == p[0]));
    end
  end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import simd_issue_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GRP_W-1:0]  ld_final,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CLS_W-1:0]  ld_cls,
  output logic              fire,
  output logic [GRP_W-1:0]  grp,
  output logic              last,
  output logic              busy,
  output logic              free,
  output logic [DATA_W-1:0] data,
  output logic [CLS_W-1:0]  cls
);
  logic             active_q;
  logic [GRP_W-1:0] grp_q, final_q;
  logic             at_final;

  assign at_final = (grp_q == final_q);
  assign fire = active_q;
  assign grp  = grp_q;
  assign last = active_q && at_final;
  assign busy = active_q && !at_final;
  assign free = !active_q || at_final;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      grp_q    <= '0;
      final_q  <= '0;
      data     <= '0;
      cls      <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      grp_q    <= '0;
      final_q  <= ld_final;
      data     <= ld_data;
      cls      <= ld_cls;
    end else if (active_q && at_final) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      grp_q <= grp_q + 1'b1;
    end
  end

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !at_final && !load) |=> (active_q && grp_q == $past(grp_q) + 2'd1));
  assert_no_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
  assert_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && at_final && !load) |=> !active_q);
  assert_start_group0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q && grp_q == '0));
endmodule

// File: rtl/lane_op.sv
module lane_op #(
  parameter int PIPE   = 0,
  parameter int DATA_W = 32,
  parameter int GRP_W  = 2
) (
  input  logic [DATA_W-1:0] din,
  input  logic [GRP_W-1:0]  grp,
  output logic [DATA_W-1:0] dout
);
  generate
    if (PIPE == 0) begin : g_simple
      assign dout = din + DATA_W'({grp, 3'b000});
    end else begin : g_transc
      assign dout = ~din + DATA_W'(grp);
    end
  endgenerate
endmodule

// File: rtl/simd_issue_seq.sv
module simd_issue_seq
  import simd_issue_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_valid,
  output logic              s0_ready,
  input  logic [2:0]        s0_cls,
  input  logic [1:0]        s0_simd,
  input  logic [DATA_W-1:0] s0_data,
  output logic              s0_err,
  input  logic              s1_valid,
  output logic              s1_ready,
  input  logic [2:0]        s1_cls,
  input  logic [1:0]        s1_simd,
  input  logic [DATA_W-1:0] s1_data,
  output logic              s1_err,
  output logic              p0_fire,
  output logic [1:0]        p0_group,
  output logic              p0_last,
  output logic [DATA_W-1:0] p0_result,
  output logic              p0_busy,
  output logic              p1_fire,
  output logic [1:0]        p1_group,
  output logic              p1_last,
  output logic [DATA_W-1:0] p1_result,
  output logic              p1_busy
);
  localparam int NPIPE = 2;

  logic [NPIPE-1:0] load, from_b, free, fire, last, busy;
  logic             g0, g1, bad0, bad1, tgt0, tgt1;
  logic [GRP_W-1:0]  grp   [NPIPE];
  logic [DATA_W-1:0] sdata [NPIPE];
  logic [DATA_W-1:0] res   [NPIPE];
  logic [CLS_W-1:0]  scls  [NPIPE];

  issue_router u_router (
    .a_valid(s0_valid), .a_cls(s0_cls), .a_wid(s0_simd),
    .b_valid(s1_valid), .b_cls(s1_cls), .b_wid(s1_simd),
    .pipe_free(free), .a_ready(s0_ready), .b_ready(s1_ready),
    .a_grant(g0), .b_grant(g1), .a_bad(bad0), .b_bad(bad1),
    .a_tgt(tgt0), .b_tgt(tgt1), .load(load), .from_b(from_b)
  );

  generate
    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
      phase_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load[p]),
        .ld_final(from_b[p] ? final_group(s1_simd) : final_group(s0_simd)),
        .ld_data(from_b[p] ? s1_data : s0_data),
        .ld_cls(from_b[p] ? s1_cls : s0_cls),
        .fire(fire[p]), .grp(grp[p]), .last(last[p]), .busy(busy[p]),
        .free(free[p]), .data(sdata[p]), .cls(scls[p])
      );
      lane_op #(.PIPE(p), .DATA_W(DATA_W), .GRP_W(GRP_W)) u_op (
        .din(sdata[p]), .grp(grp[p]), .dout(res[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_err <= 1'b0;
      s1_err <= 1'b0;
    end else begin
      s0_err <= s0_valid && bad0;
      s1_err <= s1_valid && bad1;
    end
  end

  assign p0_fire = fire[0];  assign p0_group = grp[0];  assign p0_last = last[0];
  assign p0_result = res[0]; assign p0_busy = busy[0];
  assign p1_fire = fire[1];  assign p1_group = grp[1];  assign p1_last = last[1];
  assign p1_result = res[1]; assign p1_busy = busy[1];

  assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (g0 && g1) |-> (tgt0 != tgt1));
  assert_bad_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_valid && bad0) |-> (!g0 && s0_ready));
  assert_err_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && bad1) |=> s1_err);
  assert_route_simple_R1: assert property (@(posedge clk) disable iff (!rst_n)
    p0_fire |-> !scls[0][2]);
  assert_route_transc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    p1_fire |-> (scls[1][2] && scls[1] != 3'd7));
endmodule

// File: tb/tb_simd_issue_seq.sv
module tb_simd_issue_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic s0_valid = 0, s1_valid = 0;
  logic [2:0] s0_cls = 0, s1_cls = 0;
  logic [1:0] s0_simd = 0, s1_simd = 0;
  logic [31:0] s0_data = 0, s1_data = 0;
  logic s0_ready, s1_ready, s0_err, s1_err;
  logic p0_fire, p0_last, p0_busy, p1_fire, p1_last, p1_busy;
  logic [1:0] p0_group, p1_group;
  logic [31:0] p0_result, p1_result;

  simd_issue_seq #(.DATA_W(32)) dut (.*);

  int checks = 0, failures = 0;
  bit m_act[2], m_err[2];
  logic [1:0] m_grp[2], m_fin[2];
  logic [31:0] m_data[2];
  logic [2:0] m_cls[2];
  bit acc0 = 0, acc1 = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit bad_f(logic [2:0] c, logic [1:0] w);
    return (c == 3'd7) || (w == 2'd3);
  endfunction
  function automatic logic [1:0] fin_f(logic [1:0] w);
    return (w == 2'd0) ? 2'd0 : (w == 2'd1) ? 2'd1 : 2'd3;
  endfunction
  function automatic logic [31:0] res_f(int p, logic [31:0] d, logic [1:0] g);
    return (p == 0) ? d + {27'd0, g, 3'b000} : ~d + {30'd0, g};
  endfunction

  task automatic cycle(bit nv0, logic [2:0] nc0, logic [1:0] nw0, logic [31:0] nd0,
                       bit nv1, logic [2:0] nc1, logic [1:0] nw1, logic [31:0] nd1);
    bit fr[2], bd0, bd1, t0, t1, er0, er1, g0, g1;
    logic f_a[2], l_a[2], b_a[2];
    logic [1:0] gr_a[2];
    logic [31:0] r_a[2];
    @(negedge clk);
    f_a[0] = p0_fire; f_a[1] = p1_fire; l_a[0] = p0_last; l_a[1] = p1_last;
    b_a[0] = p0_busy; b_a[1] = p1_busy; gr_a[0] = p0_group; gr_a[1] = p1_group;
    r_a[0] = p0_result; r_a[1] = p1_result;
    for (int p = 0; p < 2; p++) begin
      chk("R1 fire", {31'd0, f_a[p]}, {31'd0, m_act[p]});
      chk("R5 busy", {31'd0, b_a[p]}, {31'd0, m_act[p] && m_grp[p] != m_fin[p]});
      if (m_act[p] && f_a[p]) begin
        chk("R4 group", {30'd0, gr_a[p]}, {30'd0, m_grp[p]});
        chk("R3 last", {31'd0, l_a[p]}, {31'd0, m_grp[p] == m_fin[p]});
        chk("R9 result", r_a[p], res_f(p, m_data[p], m_grp[p]));
      end
    end
    chk("R8 err0", {31'd0, s0_err}, {31'd0, m_err[0]});
    chk("R8 err1", {31'd0, s1_err}, {31'd0, m_err[1]});
    if (!(s0_valid && !acc0)) begin
      s0_valid = nv0; s0_cls = nc0; s0_simd = nw0; s0_data = nd0;
    end
    if (!(s1_valid && !acc1)) begin
      s1_valid = nv1; s1_cls = nc1; s1_simd = nw1; s1_data = nd1;
    end
    #1;
    for (int p = 0; p < 2; p++) fr[p] = !m_act[p] || (m_grp[p] == m_fin[p]);
    bd0 = bad_f(s0_cls, s0_simd); bd1 = bad_f(s1_cls, s1_simd);
    t0 = s0_cls[2]; t1 = s1_cls[2];
    er0 = bd0 || fr[t0];
    er1 = bd1 || (fr[t1] && !(s0_valid && !bd0 && t0 == t1));
    chk("R6 ready0", {31'd0, s0_ready}, {31'd0, er0});
    chk("R7 ready1", {31'd0, s1_ready}, {31'd0, er1});
    g0 = s0_valid && !bd0 && er0;
    g1 = s1_valid && !bd1 && er1;
    acc0 = s0_valid && er0;
    acc1 = s1_valid && er1;
    for (int p = 0; p < 2; p++) begin
      if (g0 && t0 == p[0]) begin
        m_act[p] = 1; m_grp[p] = 0; m_fin[p] = fin_f(s0_simd);
        m_data[p] = s0_data; m_cls[p] = s0_cls;
      end else if (g1 && t1 == p[0]) begin
        m_act[p] = 1; m_grp[p] = 0; m_fin[p] = fin_f(s1_simd);
        m_data[p] = s1_data; m_cls[p] = s1_cls;
      end else if (m_act[p]) begin
        if (m_grp[p] == m_fin[p]) m_act[p] = 0;
        else m_grp[p] = m_grp[p] + 2'd1;
      end
    end
    m_err[0] = s0_valid && bd0;
    m_err[1] = s1_valid && bd1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_act[p] = 0; m_err[p] = 0; m_grp[p] = 0; m_fin[p] = 0; m_data[p] = 0; m_cls[p] = 0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 fire", {30'd0, p0_fire, p1_fire}, 32'd0);
    chk("R10 busy", {30'd0, p0_busy, p1_busy}, 32'd0);
    chk("R10 err", {30'd0, s0_err, s1_err}, 32'd0);
    chk("R10 ready", {30'd0, s0_ready, s1_ready}, 32'd3);
    rst_n = 1'b1;
    // R2 / R3 / R4: single instructions of each width on each pipe
    cycle(1, 3'd1, 2'd0, 32'h100, 0, 0, 0, 0); idle(3);
    cycle(1, 3'd4, 2'd1, 32'h200, 0, 0, 0, 0); idle(4);
    cycle(1, 3'd2, 2'd2, 32'h300, 0, 0, 0, 0); idle(6);
    // R5: back-to-back SIMD32 then SIMD8 on pipe 0
    cycle(1, 3'd0, 2'd2, 32'h400, 0, 0, 0, 0);
    cycle(1, 3'd3, 2'd0, 32'h500, 0, 0, 0, 0); idle(8);
    // R6: both slots to different pipes
    cycle(1, 3'd0, 2'd1, 32'h600, 1, 3'd5, 2'd2, 32'h700); idle(6);
    // R7: both slots to the same pipe
    cycle(1, 3'd6, 2'd2, 32'h800, 1, 3'd4, 2'd1, 32'h900); idle(10);
    // R8: illegal class and illegal width
    cycle(1, 3'd7, 2'd0, 32'hA00, 1, 3'd1, 2'd3, 32'hB00); idle(3);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r0, r1;
      r0 = $urandom; r1 = $urandom;
      cycle(r0[3:0] < 11, r0[6:4], (r0[11:8] == 0) ? 2'd3 : 2'(r0[13:12] % 3), $urandom,
            r1[3:0] < 11, r1[6:4], (r1[11:8] == 0) ? 2'd3 : 2'(r1[13:12] % 3), $urandom);
    end
    idle(8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule